// File: doc/BRIEF.md
# Regulator Fault Response Controller

This block decides what happens when one regulator output leaves its allowed voltage band. Two synchronized comparator levels, one for over-voltage and one for under-voltage, feed a single sticky fault flag. A response-select bit picks the action. In the default mode a fault both raises the flag and requests shutdown of the output. In the alternative mode the output is left running and only the flag is raised, so the processor can decide what to do. The processor can still force a shutdown through a software input.

Fault detection is blanked whenever the output voltage is being moved on purpose. It stays blanked while a voltage-scaling ramp is busy. It also stays blanked for a settling window of `SETTLE_CYC` clock cycles after the ramp ends, which is 1 ms at the chosen clock. This keeps a ramp or its overshoot from tripping the output. The window starts again from the last cycle in which the ramp was busy or reported done.

Top module: `fault_resp_ctrl`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), fault_flag and shutdown_req are both 0.
- R2: With resp_sel = 0 (shutdown response, the default encoding), an unmasked ov_in or uv_in level sampled at a clock edge sets fault_flag and shutdown_req from that edge on.
- R3: With resp_sel = 1 (flag-only response), an unmasked fault sets fault_flag and leaves shutdown_req unchanged.
- R4: ov_in and uv_in set the same single fault_flag bit, and either alone is enough.
- R5: At any edge where scale_busy is 1, ov_in and uv_in have no effect on fault_flag or shutdown_req.
- R6: If scale_done is sampled high at edge k (with scale_busy low), faults are also ignored at edge k and at edges k+1 through k+SETTLE_CYC, and are accepted again from edge k+SETTLE_CYC+1.
- R7: The settling window restarts from the last edge at which scale_busy or scale_done was high. A ramp that begins during a window extends the masking, so faults are ignored up to SETTLE_CYC edges after the last busy edge.
- R8: The masking of R5 to R7 behaves the same for resp_sel = 0 and resp_sel = 1.
- R9: fault_flag and shutdown_req are sticky. Both clear at the edge after flag_clr is sampled high, unless a new unmasked fault is sampled at that same edge, in which case the fault wins.
- R10: sw_shutdown sampled high sets shutdown_req from that edge on without changing fault_flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ov_in | input | 1 | Synchronized over-voltage comparator level |
| uv_in | input | 1 | Synchronized under-voltage comparator level |
| resp_sel | input | 1 | Response choice: 0 shut down and flag, 1 flag only |
| scale_busy | input | 1 | High while a voltage-scaling ramp is in progress |
| scale_done | input | 1 | One-cycle pulse when the ramp reports completion |
| flag_clr | input | 1 | Processor strobe that clears the flag and the shutdown request |
| sw_shutdown | input | 1 | Processor strobe that requests shutdown |
| fault_flag | output | 1 | Sticky fault flag shared by over- and under-voltage events |
| shutdown_req | output | 1 | Sticky request to turn the regulator output off |

## Verification
Over-voltage and under-voltage events are applied separately in each response mode. This shows that both events reach the same flag and that only the shutdown response drives shutdown_req. Faults are held on through a busy ramp and through the whole settling window, and are then accepted exactly one edge after the window ends. Moving that acceptance edge in either direction would fail a check. A second ramp started inside a window shows that the window restarts rather than running out from the first done pulse. Clear arriving together with a fault, software shutdown alone, and a reset in the middle of operation cover the sticky-state corners.

// File: rtl/fault_resp_pkg.sv
// Package: shared types for the regulator fault response controller.
// Assumes: one response-select bit per regulator, 0 being the reset default.
package fault_resp_pkg;
    typedef enum logic {
        RESP_SHUTDOWN  = 1'b0,
        RESP_FLAG_ONLY = 1'b1
    } resp_mode_e;
endpackage

// File: rtl/blank_timer.sv
// Module: blank_timer
// Produces the fault mask. Faults are masked while a scaling ramp is busy,
// in the cycle a done pulse arrives, and for SETTLE_CYC edges after the
// last busy or done cycle.
// Assumes: scale_busy and scale_done are synchronous to clk.
module blank_timer #(
    parameter int SETTLE_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scale_busy,
    input  logic scale_done,
    output logic mask
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYC);

    logic [CW-1:0] remain;
    logic          restart;

    // Purpose: any busy or done cycle (re)starts the settling window.
    assign restart = scale_busy | scale_done;

    // Purpose: load the window on restart, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (restart) begin
            remain <= LOAD;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    // Purpose: the mask covers the ramp itself and the running window.
    assign mask = restart | (remain != '0);

    assert_window_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        remain <= LOAD);
    assert_window_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (remain == LOAD));
    assert_window_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && remain != '0) |=> (remain == $past(remain) - 1'b1));
endmodule

// File: rtl/fault_latch.sv
// Module: fault_latch
// Holds the sticky fault flag and shutdown request. A fault that is not
// masked sets the flag. It also sets shutdown when the shutdown response is
// selected. A clear strobe drops both bits unless a fault arrives in the
// same cycle.
// Assumes: ov/uv already synchronized; mask comes from blank_timer.
module fault_latch
    import fault_resp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ov_in,
    input  logic uv_in,
    input  logic mask,
    input  logic resp_sel,
    input  logic flag_clr,
    input  logic sw_shutdown,
    output logic fault_flag,
    output logic shutdown_req
);
    resp_mode_e mode;
    logic       event_hit;
    logic       hw_trip;

    // Purpose: decode the response bit into the shared mode type.
    assign mode      = resp_mode_e'(resp_sel);
    // Purpose: either comparator counts as an event once blanking is over.
    assign event_hit = (ov_in | uv_in) & ~mask;
    // Purpose: only the shutdown response turns an event into a trip.
    assign hw_trip   = event_hit & (mode == RESP_SHUTDOWN);

    // Purpose: sticky flag, where a set beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_flag <= 1'b0;
        end else if (event_hit) begin
            fault_flag <= 1'b1;
        end else if (flag_clr) begin
            fault_flag <= 1'b0;
        end
    end

    // Purpose: sticky shutdown from a hardware trip or a software request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shutdown_req <= 1'b0;
        end else if (hw_trip || sw_shutdown) begin
            shutdown_req <= 1'b1;
        end else if (flag_clr) begin
            shutdown_req <= 1'b0;
        end
    end

    assert_trip_shutdown_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (event_hit && !resp_sel) |=> (shutdown_req && fault_flag));
    assert_flag_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (event_hit && resp_sel && !sw_shutdown && !shutdown_req) |=> !shutdown_req);
    assert_shared_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        event_hit |=> fault_flag);
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flag && !flag_clr) |=> fault_flag);
    assert_sw_shutdown_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_shutdown |=> shutdown_req);
endmodule

// File: rtl/fault_resp_ctrl.sv
// Module: fault_resp_ctrl (top)
// Per-regulator over/under-voltage response. It combines the blanking timer
// and the sticky fault latch.
// Assumes: all inputs synchronous to clk; SETTLE_CYC equals the settling
// time in clock cycles (1 ms at the system clock).
module fault_resp_ctrl #(
    parameter int SETTLE_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ov_in,
    input  logic uv_in,
    input  logic resp_sel,
    input  logic scale_busy,
    input  logic scale_done,
    input  logic flag_clr,
    input  logic sw_shutdown,
    output logic fault_flag,
    output logic shutdown_req
);
    logic mask;

    blank_timer #(.SETTLE_CYC(SETTLE_CYC)) u_blank (
        .clk        (clk),
        .rst_n      (rst_n),
        .scale_busy (scale_busy),
        .scale_done (scale_done),
        .mask       (mask)
    );

    fault_latch u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .ov_in        (ov_in),
        .uv_in        (uv_in),
        .mask         (mask),
        .resp_sel     (resp_sel),
        .flag_clr     (flag_clr),
        .sw_shutdown  (sw_shutdown),
        .fault_flag   (fault_flag),
        .shutdown_req (shutdown_req)
    );

    assert_busy_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        scale_busy |=> !$rose(fault_flag));
    assert_done_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        scale_done |=> !$rose(fault_flag));
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!fault_flag && !shutdown_req));
endmodule

// File: tb/fault_resp_ctrl_tb.sv
module fault_resp_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 4;
    localparam int NVEC       = 34;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ov_in = 1'b0, uv_in = 1'b0, resp_sel = 1'b0;
    logic scale_busy = 1'b0, scale_done = 1'b0, flag_clr = 1'b0, sw_shutdown = 1'b0;
    logic fault_flag, shutdown_req;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_resp_ctrl #(.SETTLE_CYC(SETTLE)) u_dut (
        .clk(clk), .rst_n(rst_n), .ov_in(ov_in), .uv_in(uv_in),
        .resp_sel(resp_sel), .scale_busy(scale_busy), .scale_done(scale_done),
        .flag_clr(flag_clr), .sw_shutdown(sw_shutdown),
        .fault_flag(fault_flag), .shutdown_req(shutdown_req)
    );

    // Row bits: [8]sel [7]ov [6]uv [5]busy [4]done [3]clr [2]sw | [1]exp flag [0]exp shutdown
    localparam logic [8:0] VEC [NVEC] = '{
        9'b0_0_0_0_0_0_0_0_0, //  0 idle
        9'b0_1_0_0_0_0_0_1_1, //  1 R2 ov, shutdown mode
        9'b0_0_0_0_0_1_0_0_0, //  2 R9 clear
        9'b0_0_1_0_0_0_0_1_1, //  3 R4 uv on same flag
        9'b0_0_0_0_0_1_0_0_0, //  4 R9 clear
        9'b1_1_0_0_0_0_0_1_0, //  5 R3 flag only
        9'b1_0_0_0_0_0_0_1_0, //  6 R9 sticky
        9'b1_1_0_0_0_1_0_1_0, //  7 R9 fault beats clear
        9'b0_0_0_0_0_1_0_0_0, //  8 clear
        9'b0_0_0_0_0_0_1_0_1, //  9 R10 sw shutdown, flag untouched
        9'b0_0_0_0_0_1_0_0_0, // 10 clear
        9'b0_1_0_1_0_0_0_0_0, // 11 R5 busy masks
        9'b0_1_0_0_0_0_0_0_0, // 12 R7 window after busy
        9'b0_1_0_0_0_0_0_0_0, // 13
        9'b0_1_0_0_0_0_0_0_0, // 14
        9'b0_1_0_0_0_0_0_0_0, // 15 last masked edge
        9'b0_1_0_0_0_0_0_1_1, // 16 R7 accepted
        9'b0_0_0_0_0_1_0_0_0, // 17 clear
        9'b1_1_0_0_1_0_0_0_0, // 18 R6 done edge masked, flag-only mode
        9'b1_1_0_0_0_0_0_0_0, // 19 R8
        9'b1_1_0_0_0_0_0_0_0, // 20
        9'b1_1_0_0_0_0_0_0_0, // 21
        9'b1_1_0_0_0_0_0_0_0, // 22 edge k+SETTLE still masked
        9'b1_1_0_0_0_0_0_1_0, // 23 R6 accepted at k+SETTLE+1
        9'b0_0_0_0_0_1_0_0_0, // 24 clear
        9'b0_0_0_0_1_0_0_0_0, // 25 done
        9'b0_0_0_0_0_0_0_0_0, // 26
        9'b0_0_0_1_0_0_0_0_0, // 27 R7 busy inside window
        9'b0_1_0_0_0_0_0_0_0, // 28 R7 restarted window
        9'b0_0_1_0_0_0_0_0_0, // 29
        9'b0_1_0_0_0_0_0_0_0, // 30
        9'b0_0_1_0_0_0_0_0_0, // 31
        9'b0_0_1_0_0_0_0_1_1, // 32 R7 accepted after restart
        9'b0_0_0_0_0_1_0_0_0  // 33 clear
    };

    task automatic check(input string req, input int tag, input logic ef, input logic es);
        checks++;
        if (fault_flag !== ef || shutdown_req !== es) begin
            errors++;
            $display("FAIL %s step %0d: flag=%b shdn=%b expected flag=%b shdn=%b",
                     req, tag, fault_flag, shutdown_req, ef, es);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1 check("R1", -1, 1'b0, 1'b0);
        @(negedge clk) rst_n = 1'b1;

        // Table walk: drive at negedge, check just after the next posedge.
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            {resp_sel, ov_in, uv_in, scale_busy, scale_done, flag_clr, sw_shutdown} = VEC[i][8:2];
            @(posedge clk);
            #1 check("R2-table", i, VEC[i][1], VEC[i][0]);
        end

        // R8: busy masks in flag-only mode too
        @(negedge clk);
        {resp_sel, ov_in, uv_in, scale_busy, scale_done, flag_clr, sw_shutdown} = 7'b1_1_1_1_0_0_0;
        @(posedge clk); #1 check("R8", 100, 1'b0, 1'b0);

        // R10: sw shutdown in flag-only mode after a flagged fault
        @(negedge clk);
        {resp_sel, ov_in, uv_in, scale_busy, scale_done, flag_clr, sw_shutdown} = 7'b1_0_0_0_0_0_0;
        repeat (SETTLE + 1) @(posedge clk);
        @(negedge clk) ov_in = 1'b1;
        @(posedge clk); #1 check("R3", 101, 1'b1, 1'b0);
        @(negedge clk) begin ov_in = 1'b0; sw_shutdown = 1'b1; end
        @(posedge clk); #1 check("R10", 102, 1'b1, 1'b1);

        // R1: reset mid-operation clears both sticky bits
        @(negedge clk) begin sw_shutdown = 1'b0; rst_n = 1'b0; end
        @(posedge clk); #1 check("R1", 103, 1'b0, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1 check("R1", 104, 1'b0, 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule